// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is a bank of up to sixteen general-purpose I/O pins controlled through a small register bus. Software sets a direction word, an output latch and an open-drain word. From these the block works out, for each pin, the pad output value and the pad output enable. Pins can be left unimplemented through a mask parameter. An unimplemented pin keeps its reset state, is never driven and reads as 0.

The bus carries an address, a write enable, write data and read data. Read data is registered and appears one cycle after the address. The bus is a plain control path with no back-pressure: a write completes in the cycle it is presented and a read is never stalled. Writes to the pin address and to the latch address both load the output latch, but reads from the two addresses differ. Reading the pin address returns the pin levels seen through a two-flop sampler. Reading the latch address returns the latch itself. A read-modify-write through the latch address therefore never copies input pin levels into the latch.

A per-pin analog-select input turns off the digital read path of that pin, so the pin reads 0.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every implemented direction bit is 1, the latch and open-drain words are 0, and no pad output enable is asserted.
- R2: Register addresses are: direction at 0, pin at 1, latch at 2, open-drain at 3. A direction bit of 0 makes the pin an output (pad_oe high when not open-drain); a 1 makes it an input (pad_oe low).
- R3: A write to address 1 or to address 2 loads the output latch with the write data; pad_out always equals the latch.
- R4: A read of address 1 returns the sampled pin levels, and a read of address 2 returns the latch, so a read-modify-write through address 2 never picks up input pin levels.
- R5: With open-drain bit 1 and direction bit 0, a latch 1 releases the pin (pad_oe low) and a latch 0 drives it low (pad_oe high).
- R6: An open-drain bit has no effect on a pin whose direction bit is 1.
- R7: A pin whose analog-select input is 1 reads 0 at address 1.
- R8: Bits outside the implemented mask read 0 at every address and never assert pad_oe.
- R9: Read data appears one cycle after the address is presented. A pin change made together with a read of address 1 is not yet visible in that read, and it is visible in a read presented three cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, one cycle after the address |
| pad_in | input | 16 | Pin levels from the pads |
| pad_analog | input | 16 | Per-pin analog select; 1 turns off the digital read |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable |

## Verification
A table of direction, latch and open-drain words is applied. It includes all-input, all-output push-pull, all open-drain and mixed words. These tell apart the direction rule, the open-drain release and the case where open-drain is ignored on input pins. With the default mask, two of the table's pins are unimplemented. Directed cases then run a pin pattern against a zero latch, which separates the pin read from the latch read, and a read-modify-write, which shows that pin levels do not leak into the latch. Further cases check the analog masking, and a pin change timed against reads, which exposes the sampler delay and the read latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR = 2'd0,
    REG_PIN = 2'd1,
    REG_LAT = 2'd2,
    REG_ODC = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  reg_addr_e           addr,
  input  logic                we,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] lat_q,
  output logic [NUM_PINS-1:0] odc_q
);
  logic lat_hit;
  assign lat_hit = we && (addr == REG_PIN || addr == REG_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      odc_q <= '0;
    end else begin
      if (we && addr == REG_DIR) dir_q <= wdata | ~IMPL_MASK;
      if (lat_hit)               lat_q <= wdata & IMPL_MASK;
      if (we && addr == REG_ODC) odc_q <= wdata & IMPL_MASK;
    end
  end

  assert_lat_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hit |=> lat_q == $past(wdata & IMPL_MASK));

  assert_lat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_hit |=> $stable(lat_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_sync
);
  logic [NUM_PINS-1:0] stage1;
  logic [1:0]          warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      pin_sync <= '0;
      warm     <= '0;
    end else begin
      stage1   <= pin_raw;
      pin_sync <= stage1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assert_two_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |=> pin_sync == $past(pin_raw, 2));
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] lat_q,
  input  logic [NUM_PINS-1:0] odc_q,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  assign pad_out = lat_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_comb begin
      if (dir_q[i])      pad_oe[i] = 1'b0;
      else if (odc_q[i]) pad_oe[i] = ~lat_q[i];
      else               pad_oe[i] = 1'b1;
    end

    assert_input_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[i] |-> !pad_oe[i]);

    assert_od_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_q[i] && odc_q[i] && pad_out[i]) |-> !pad_oe[i]);
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 16'h3FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] pad_analog,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  reg_addr_e           addr;
  logic [NUM_PINS-1:0] dir_q, lat_q, odc_q, pin_sync, pin_view;

  assign addr = reg_addr_e'(bus_addr);

  gpio_regs #(.NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(bus_we), .wdata(bus_wdata),
    .dir_q(dir_q), .lat_q(lat_q), .odc_q(odc_q)
  );

  gpio_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pad_in), .pin_sync(pin_sync)
  );

  gpio_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .lat_q(lat_q), .odc_q(odc_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pin_view = pin_sync & ~pad_analog & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      unique case (addr)
        REG_DIR: bus_rdata <= dir_q & IMPL_MASK;
        REG_PIN: bus_rdata <= pin_view;
        REG_LAT: bus_rdata <= lat_q;
        REG_ODC: bus_rdata <= odc_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_analog_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_PIN) |=> (bus_rdata & $past(pad_analog)) == '0);

  assert_unimpl_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata | pad_oe) & ~IMPL_MASK) == '0);
endmodule

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_analog = '0;
  logic [15:0] pad_out, pad_oe;

  localparam logic [15:0] MASK = 16'h3FFF;
  localparam logic [1:0] A_DIR = 2'd0, A_PIN = 2'd1, A_LAT = 2'd2, A_ODC = 2'd3;

  // {dir, lat, odc, expected pad_oe, expected pad_out}
  localparam int NV = 8;
  localparam logic [79:0] VEC [NV] = '{
    {16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'hA5A5, 16'h0000, 16'h3FFF, 16'h25A5},
    {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h3FFF},
    {16'h0000, 16'h0F0F, 16'h00FF, 16'h3FF0, 16'h0F0F},
    {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    {16'h00FF, 16'h0000, 16'h0000, 16'h3F00, 16'h0000},
    {16'hFF00, 16'h1234, 16'h1030, 16'h00CF, 16'h1234},
    {16'h0000, 16'h3000, 16'h3000, 16'h0FFF, 16'h3000}
  };

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;

  gpio_port_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_analog(pad_analog), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_DIR, v); chk("R1 dir reset", v, MASK);
    rd(A_LAT, v); chk("R1 lat reset", v, 16'h0000);
    rd(A_ODC, v); chk("R1 odc reset", v, 16'h0000);
    chk("R1 oe reset", pad_oe, 16'h0000);

    // R2 R5 R6 R8: table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_DIR, VEC[i][79:64]);
      wr(A_LAT, VEC[i][63:48]);
      wr(A_ODC, VEC[i][47:32]);
      @(negedge clk);
      chk($sformatf("R2 R5 R6 pad_oe vec%0d", i), pad_oe, VEC[i][31:16]);
      chk($sformatf("R3 pad_out vec%0d", i), pad_out, VEC[i][15:0]);
      rd(A_DIR, v); chk($sformatf("R8 dir read vec%0d", i), v, VEC[i][79:64] & MASK);
      rd(A_ODC, v); chk($sformatf("R8 odc read vec%0d", i), v, VEC[i][47:32] & MASK);
    end

    // R3: write through pin address loads latch
    wr(A_PIN, 16'h5A5A);
    rd(A_LAT, v); chk("R3 pin-address write", v, 16'h1A5A);
    chk("R3 pad_out follows", pad_out, 16'h1A5A);

    // R4: pin read versus latch read, read-modify-write
    wr(A_DIR, 16'hFFFF);
    wr(A_LAT, 16'h0000);
    pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd(A_PIN, v); chk("R4 pin read", v, MASK);
    rd(A_LAT, v); chk("R4 latch read", v, 16'h0000);
    wr(A_LAT, v | 16'h0001);
    rd(A_LAT, v); chk("R4 rmw no pin leak", v, 16'h0001);

    // R7: analog select masks pin read
    pad_analog = 16'h00FF;
    rd(A_PIN, v); chk("R7 analog masked", v, 16'h3F00);
    pad_analog = 16'h0000;

    // R9: sampler delay and read latency
    @(negedge clk);
    pad_in = 16'h0000; bus_addr = A_PIN; bus_we = 1'b0;
    @(negedge clk);
    chk("R9 change not yet visible", bus_rdata, MASK);
    @(negedge clk);
    @(negedge clk);
    chk("R9 change visible later", bus_rdata, 16'h0000);
    pad_in = 16'h2468;
    repeat (2) @(negedge clk);
    rd(A_PIN, v); chk("R9 new pattern", v, 16'h2468);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule